// File: doc/BRIEF.md
# PCI Interrupt Aggregation Register

This block gathers the interrupt sources of a PCI host bridge into one 32-bit register and raises a single shared interrupt towards the system interrupt controller. Four active-low INTx lines from the bus are synchronised and shown as level pending flags. Six one-cycle error event pulses from the bridge core each set a sticky pending flag. Every source has an enable bit in the upper half of the same word, sixteen positions above its pending flag. A source is active when it is both pending and enabled. The shared interrupt output is the OR of all active sources.

Two group outputs tell software which side needs attention: one for the error sources and one for the INTx lines. Software reads the register, handles the active sources, and clears the error flags by writing zero to them. A default-enable strobe loads a preset set of error enables. A mode input picks that preset: the reduced set covers only the abort events, and the full set also covers the parity and system-error events.

The register is always readable on the read-data port, and the write strobe replaces the enable half of the word. Routing to processor interrupt numbers and slot swizzling are not part of this block.

Top module: `pci_irq_collector`

## Requirements
- R1: Reset (synchronous, active low) clears every pending and enable bit, so the read data, irq_o, err_grp_o and intx_grp_o are all zero afterwards.
- R2: Bits 3:0 are pending flags for INTA, INTB, INTC and INTD, taken from intx_n_i[0..3] in that order. A flag is 1 while its line is low. The line passes through a two-stage synchroniser, so a change on the pin shows in the register after exactly two rising edges.
- R3: Error pulse err_evt_i[k] sets pending bit 4+k, and the flag stays set until it is written to zero. The bit order is: 4 data parity error detected, 5 target abort signalled, 6 target abort received, 7 master abort received, 8 system error signalled, 9 parity error detected.
- R4: A write (reg_wr_i) keeps an error pending bit where the write data bit is 1 and clears it where the data bit is 0. A write never sets a pending bit. An event pulse in the same cycle as a clearing write leaves its flag set.
- R5: A write loads the enable bits 25:16 from the write data, where bit 16+n enables source n. Writes to bits 3:0, 15:10 and 31:26 have no effect, and bits 15:10 and 31:26 always read as zero.
- R6: irq_o is 1 exactly when some bit of (pending AND enable) is 1.
- R7: err_grp_o is 1 when any active bit lies in 9:4. intx_grp_o is 1 when any active bit lies in 3:0.
- R8: With reg_wr_i low, the default strobe dflt_i loads error enables 25:20. When full_err_mode_i is 0 it loads only bits 21, 22 and 23 (the abort events). When full_err_mode_i is 1 it loads all six. The INTx enables and all pending bits stay as they are. If reg_wr_i and dflt_i are high together, the write takes precedence.
- R9: Writing the value zero disables every source and clears every error pending flag, so irq_o drops once no INTx line is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intx_n_i | input | 4 | Asynchronous active-low INTx lines, INTA at bit 0 |
| err_evt_i | input | 6 | One-cycle error event pulses, mapped to pending bits 9:4 |
| full_err_mode_i | input | 1 | Selects the error-enable preset: 0 is the reduced set, 1 is the full set |
| dflt_i | input | 1 | Loads the selected error-enable preset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register contents |
| irq_o | output | 1 | Shared interrupt output |
| err_grp_o | output | 1 | Some error source is active |
| intx_grp_o | output | 1 | Some INTx source is active |

## Verification
The assertions assume that err_evt_i carries clean synchronous pulses and that dflt_i is only acted on when reg_wr_i is low. They also assume that intx_n_i is the only asynchronous input. The stimulus drives all inputs at falling edges. It holds each INTx level for at least three edges before the register is compared, and gives every error event a single cycle. It places the coincidences the requirements name (a clearing write with an event, and a write with a default strobe) in the same cycle on purpose.

// File: rtl/pirq_pkg.sv
// Package: shared sizes and the error-enable preset for the PCI interrupt
// aggregation register. Assumes error sources sit directly above the INTx
// sources in the pending field.
package pirq_pkg;
    localparam int INTX_N   = 4;
    localparam int ERR_N    = 6;
    localparam int SRC_N    = INTX_N + ERR_N;
    localparam int MASK_OFS = 16;
    localparam int WORD_W   = 32;

    // Reduced preset: abort events only (error indices 1, 2, 3).
    localparam logic [ERR_N-1:0] ERR_REDUCED = 6'b001110;

    // Pick the error-enable preset for the given mode.
    function automatic logic [ERR_N-1:0] err_preset(input logic full_mode);
        return full_mode ? {ERR_N{1'b1}} : ERR_REDUCED;
    endfunction
endpackage

// File: rtl/pirq_line_sync.sv
// Module: multi-stage synchroniser for a bundle of active-low lines.
// Assumes each line is a slow level. Every stage resets to the inactive
// (high) value.
module pirq_line_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_n_i,
    output logic [W-1:0] line_n_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the line value one stage further each clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '1;
                else if (s == 0)
                    stage_q[s] <= line_n_i;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign line_n_o = stage_q[STAGES-1];
endmodule

// File: rtl/pirq_err_latch.sv
// Module: sticky error pending flags. An event pulse sets its flag. A write
// keeps a flag where the data bit is 1 and clears it where it is 0. An event
// pulse takes precedence over a clear in the same cycle.
module pirq_err_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // Update the flags: clear by write, then set by event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (wr_i ? (flags_q & keep_i) : flags_q) | evt_i;
    end

    assign flags_o = flags_q;

    // R3: an event leaves its flag set on the next cycle.
    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

    // R3: without a write, no flag drops.
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4: a write without an event never raises a flag.
    assert_write_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && evt_i == '0) |=> ((flags_q & ~$past(flags_q)) == '0));
endmodule

// File: rtl/pirq_mask_reg.sv
// Module: enable bits for all sources. A write loads every enable bit. The
// default strobe loads only the error enables with the preset for the mode.
// A write takes precedence over the strobe.
module pirq_mask_reg
    import pirq_pkg::*;
#(
    parameter int NI = INTX_N,
    parameter int NE = ERR_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [NI+NE-1:0] wmask_i,
    input  logic             dflt_i,
    input  logic             full_i,
    output logic [NI+NE-1:0] mask_o
);
    logic [NI+NE-1:0] mask_q;

    // Load the enables from a write or from the preset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_i)
            mask_q <= wmask_i;
        else if (dflt_i)
            mask_q[NI +: NE] <= err_preset(full_i);
    end

    assign mask_o = mask_q;

    // R8: the default strobe leaves the INTx enables alone.
    assert_dflt_keeps_intx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dflt_i && !wr_i) |=> (mask_q[NI-1:0] == $past(mask_q[NI-1:0])));

    // R5: with no write and no strobe the enables hold.
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dflt_i && !wr_i) |=> $stable(mask_q));
endmodule

// File: rtl/pirq_combine.sv
// Module: forms the active set (pending AND enable) and the group and shared
// outputs. Purely combinational.
module pirq_combine #(
    parameter int NI = 4,
    parameter int NE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NI+NE-1:0] pend_i,
    input  logic [NI+NE-1:0] mask_i,
    output logic             irq_o,
    output logic             err_grp_o,
    output logic             intx_grp_o
);
    logic [NI+NE-1:0] active;

    // Derive the active sources and the group outputs.
    always_comb begin
        active     = pend_i & mask_i;
        intx_grp_o = |active[NI-1:0];
        err_grp_o  = |active[NI +: NE];
        irq_o      = |active;
    end

    // R7: the shared output is raised exactly when a group is raised.
    assert_groups_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (err_grp_o | intx_grp_o));

    // R6: no active source implies no shared interrupt.
    assert_irq_needs_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) == '0) |-> !irq_o);
endmodule

// File: rtl/pci_irq_collector.sv
// Module: top of the PCI interrupt aggregation register. Pending flags are
// in the low half and enables sit MASK_OFS positions above them. Assumes
// err_evt_i carries synchronous single-cycle pulses and intx_n_i is
// asynchronous.
module pci_irq_collector
    import pirq_pkg::*;
#(
    parameter int NI       = INTX_N,
    parameter int NE       = ERR_N,
    parameter int OFS      = MASK_OFS,
    parameter int DW       = WORD_W,
    parameter int SYNC_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] intx_n_i,
    input  logic [NE-1:0] err_evt_i,
    input  logic          full_err_mode_i,
    input  logic          dflt_i,
    input  logic          reg_wr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o,
    output logic          err_grp_o,
    output logic          intx_grp_o
);
    localparam int NS = NI + NE;

    logic [NI-1:0] intx_n_sync;
    logic [NE-1:0] err_flags;
    logic [NS-1:0] mask;
    logic [NS-1:0] pend;
    logic          unused_wbits;

    assign unused_wbits = ^{reg_wdata_i[DW-1:OFS+NS], reg_wdata_i[OFS-1:NS],
                            reg_wdata_i[NI-1:0]};

    pirq_line_sync #(.W(NI), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n_i (intx_n_i),
        .line_n_o (intx_n_sync)
    );

    pirq_err_latch #(.N(NE)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (err_evt_i),
        .wr_i    (reg_wr_i),
        .keep_i  (reg_wdata_i[NI +: NE]),
        .flags_o (err_flags)
    );

    pirq_mask_reg #(.NI(NI), .NE(NE)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .wmask_i (reg_wdata_i[OFS +: NS]),
        .dflt_i  (dflt_i),
        .full_i  (full_err_mode_i),
        .mask_o  (mask)
    );

    assign pend = {err_flags, ~intx_n_sync};

    pirq_combine #(.NI(NI), .NE(NE)) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .mask_i     (mask),
        .irq_o      (irq_o),
        .err_grp_o  (err_grp_o),
        .intx_grp_o (intx_grp_o)
    );

    // Assemble the read-back word from pending flags and enables.
    always_comb begin
        reg_rdata_o           = '0;
        reg_rdata_o[NS-1:0]   = pend;
        reg_rdata_o[OFS +: NS] = mask;
    end

    // R9: writing zero leaves no error flag set unless an event arrived.
    assert_zero_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i == '0 && err_evt_i == '0) |=>
        (reg_rdata_o[OFS +: NS] == '0 && reg_rdata_o[NS-1:NI] == '0));
endmodule

// File: tb/pci_irq_collector_bench.sv
// Bench: a vector table walked by one loop, then directed tests for reset,
// synchroniser latency and same-cycle corner cases.
module pci_irq_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  intx_n;
    logic [5:0]  evt;
    logic        mode, dflt, wr;
    logic [31:0] wdata, rdata;
    logic        irq, eg, ig;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pci_irq_collector u_pci_irq_collector (
        .clk (clk), .rst_n (rst_n), .intx_n_i (intx_n), .err_evt_i (evt),
        .full_err_mode_i (mode), .dflt_i (dflt), .reg_wr_i (wr),
        .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq),
        .err_grp_o (eg), .intx_grp_o (ig)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wdata;
        logic        dflt;
        logic        mode;
        logic [3:0]  intx_n;
        logic [5:0]  evt;
        logic [31:0] rd;
        logic        irq;
        logic        eg;
        logic        ig;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R8 reduced preset
        '{1'b0, 32'h0, 1'b1, 1'b0, 4'hF, 6'h00, 32'h00E0_0000, 1'b0, 1'b0, 1'b0},
        // R3 master abort received -> bit 7, enabled
        '{1'b0, 32'h0, 1'b0, 1'b0, 4'hF, 6'h08, 32'h00E0_0080, 1'b1, 1'b1, 1'b0},
        // R3 data parity -> bit 4, not enabled
        '{1'b0, 32'h0, 1'b0, 1'b0, 4'hF, 6'h01, 32'h00E0_0090, 1'b1, 1'b1, 1'b0},
        // R4 clear bit 7, keep bit 4
        '{1'b1, 32'h00E0_0010, 1'b0, 1'b0, 4'hF, 6'h00, 32'h00E0_0010, 1'b0, 1'b0, 1'b0},
        // R8 full preset
        '{1'b0, 32'h0, 1'b1, 1'b1, 4'hF, 6'h00, 32'h03F0_0010, 1'b1, 1'b1, 1'b0},
        // R2 INTB low, not enabled
        '{1'b0, 32'h0, 1'b0, 1'b1, 4'hD, 6'h00, 32'h03F0_0012, 1'b1, 1'b1, 1'b0},
        // R5/R7 enable INTB only, errors cleared
        '{1'b1, 32'h0002_0000, 1'b0, 1'b1, 4'hD, 6'h00, 32'h0002_0002, 1'b1, 1'b0, 1'b1},
        // R4/R5 all-ones write: no set, reserved bits ignored
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'hF, 6'h00, 32'h03FF_0000, 1'b0, 1'b0, 1'b0},
        // R6 every source active
        '{1'b0, 32'h0, 1'b0, 1'b0, 4'h0, 6'h3F, 32'h03FF_03FF, 1'b1, 1'b1, 1'b1},
        // R9 zero write, lines released
        '{1'b1, 32'h0, 1'b0, 1'b0, 4'hF, 6'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr = 1'b0; dflt = 1'b0; evt = '0; wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; intx_n = 4'hF; mode = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 outputs", {29'h0, irq, eg, ig}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr = TBL[i].wr; wdata = TBL[i].wdata; dflt = TBL[i].dflt;
            mode = TBL[i].mode; intx_n = TBL[i].intx_n; evt = TBL[i].evt;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R3/R4/R5 table %0d rdata", i), rdata, TBL[i].rd);
            chk($sformatf("R6 table %0d irq", i), {31'h0, irq}, {31'h0, TBL[i].irq});
            chk($sformatf("R7 table %0d err group", i), {31'h0, eg}, {31'h0, TBL[i].eg});
            chk($sformatf("R7 table %0d intx group", i), {31'h0, ig}, {31'h0, TBL[i].ig});
        end

        // R2 synchroniser latency: INTC low visible after the second edge only
        @(negedge clk); intx_n = 4'hB;
        @(posedge clk); @(negedge clk);
        chk("R2 one edge", rdata, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R2 two edges", rdata, 32'h0000_0004);
        intx_n = 4'hF;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R2 release", rdata, 32'h0);

        // R4 event in the same cycle as a clearing write keeps its flag
        wr = 1'b1; wdata = 32'h0; evt = 6'h20;
        @(posedge clk); @(negedge clk); idle_inputs();
        chk("R4 event beats clear", rdata, 32'h0000_0200);

        // R8 write takes precedence over default strobe
        wr = 1'b1; wdata = 32'h0001_0200; dflt = 1'b1; mode = 1'b1;
        @(posedge clk); @(negedge clk); idle_inputs();
        chk("R8 write wins", rdata, 32'h0001_0200);

        // R8 strobe keeps INTx enable and pending
        dflt = 1'b1; mode = 1'b0;
        @(posedge clk); @(negedge clk); idle_inputs();
        chk("R8 preset keeps intx enable", rdata, 32'h00E1_0200);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-run reset", rdata, 32'h0);
        chk("R6 irq after reset", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule